// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt requests from a set of peripheral sources into a pending-status register, gates them with an enable-mask register and drives one combined interrupt line toward the processor. Each source signals an event with a single-cycle pulse. The pulse latches a pending bit that stays set until software acknowledges it. A dedicated request input from the DMA controller feeds a fixed pending bit.

Software reaches both registers over a simple register bus and may access them with 32-bit or 16-bit transfers. A write to the mask register replaces the enable pattern. A write to the status register acknowledges events with an AND rule. Each pending bit survives only if the written value and the current mask both hold a one in that position. A bit that is disabled in the mask is therefore dropped by any status write, whatever value is written. Reads have no side effects.

Top module: `irq_status_mask_ctrl`

## Requirements
- R1: Reset clears the pending status, the enable mask and the interrupt output.
- R2: A pulse on a source input sets the pending bit with the same index at the next clock edge. Without a status write, a pending bit then stays set.
- R3: The DMA request input sets pending bit 3.
- R4: A 32-bit write to the mask register (byte offset 0x074) replaces every implemented mask bit with the written value.
- R5: A 32-bit write to the status register (byte offset 0x070) sets status to status AND mask AND written value.
- R6: A status write clears every pending bit whose mask bit is zero, even when the written value is all ones.
- R7: If a source pulse arrives in the same cycle as a status write, the pending bit of that source is set after the edge.
- R8: A 16-bit write (bus_half = 1) changes only bits 15:0 of the addressed register and leaves the upper implemented bits unchanged.
- R9: cpu_irq is high exactly one cycle after (status AND mask) is non-zero, and low one cycle after it is zero.
- R10: A read returns the register's current value zero-extended, with bits at or above NUM_SRC reading as zero. A 16-bit read also returns zero in bits 31:16. A read of any other offset returns zero, a write to another offset changes nothing, and a read changes no state.
- R11: A source pulse latches its pending bit even when that bit is disabled in the mask, and in that case it does not raise cpu_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | NUM_SRC | Single-cycle event pulses, one per source |
| dma_irq | input | 1 | DMA controller request, routed to pending bit 3 |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = 16-bit access (low half), 0 = 32-bit access |
| bus_addr | input | ADDR_W | Byte offset within the I/O window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current registers |
| cpu_irq | output | 1 | Registered combined interrupt to the processor |

## Verification
Two events can land in one cycle: a peripheral pulse that raises a pending bit, and a software status write whose AND rule would clear that bit. The random phase drives sparse pulses together with status writes that carry random values and random masks. The directed phase pairs an all-zero acknowledge with a DMA request on the same edge. In both phases the read-back status is judged against a bench model, and any bit pulsed in the write cycle must read as set.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned BUS_W  = 32;
   localparam int unsigned LANE_W = 16;
   localparam int unsigned LANES  = BUS_W / LANE_W;

   typedef struct packed {
      logic             stat_wr;
      logic             mask_wr;
      logic [LANES-1:0] lanes;
   } irqc_wr_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
   import irqc_pkg::*;
#(
   parameter int unsigned    ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
   parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074
) (
   input  logic              sel,
   input  logic              wr,
   input  logic              half,
   input  logic [ADDR_W-1:0] addr,
   output irqc_wr_t          wdec,
   output logic              rd_stat,
   output logic              rd_mask
);
   if (STAT_OFS == MASK_OFS) begin : g_bad_ofs
      $error("status and mask offsets must differ");
   end
   if (STAT_OFS[1:0] != 2'b00 || MASK_OFS[1:0] != 2'b00) begin : g_bad_align
      $error("register offsets must be word aligned");
   end

   logic hit_stat, hit_mask;
   assign hit_stat = sel && (addr == STAT_OFS);
   assign hit_mask = sel && (addr == MASK_OFS);

   always_comb begin
      wdec.stat_wr = hit_stat && wr;
      wdec.mask_wr = hit_mask && wr;
      wdec.lanes   = half ? LANES'(1) : '1;
   end

   assign rd_stat = hit_stat && !wr;
   assign rd_mask = hit_mask && !wr;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 20,
   parameter int unsigned DMA_BIT = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_vec,
   input  irqc_wr_t           wdec,
   input  logic [NUM_SRC-1:0] wd,
   output logic [NUM_SRC-1:0] status,
   output logic [NUM_SRC-1:0] mask
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      localparam int unsigned LN = i / LANE_W;
      logic lane_hit;
      logic keep;
      assign lane_hit = wdec.lanes[LN];
      assign keep     = !(wdec.stat_wr && lane_hit) || (mask[i] && wd[i]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            status[i] <= 1'b0;
            mask[i]   <= 1'b0;
         end else begin
            status[i] <= (status[i] && keep) || set_vec[i];
            if (wdec.mask_wr && lane_hit) mask[i] <= wd[i];
         end
      end
   end

   a_r5_ack_word: assert property (@(posedge clk) disable iff (!rst_n)
      (wdec.stat_wr && (&wdec.lanes) && set_vec == '0)
      |=> status == ($past(status) & $past(mask) & $past(wd)));

   a_r7_pulse_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

   a_r4_mask_word: assert property (@(posedge clk) disable iff (!rst_n)
      (wdec.mask_wr && (&wdec.lanes)) |=> mask == $past(wd));

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wdec.stat_wr && set_vec == '0) |=> $stable(status));

   a_r3_dma_bit: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[DMA_BIT] |=> status[DMA_BIT]);

   if (NUM_SRC > LANE_W) begin : g_upper_chk
      a_r8_half_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
         (wdec.mask_wr && !wdec.lanes[1])
         |=> mask[NUM_SRC-1:LANE_W] == $past(mask[NUM_SRC-1:LANE_W]));
   end
endmodule

// File: rtl/irqc_line.sv
module irqc_line #(
   parameter int unsigned NUM_SRC = 20,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] status,
   input  logic [NUM_SRC-1:0] mask,
   output logic               irq
);
   logic any_live;
   assign any_live = |(status & mask);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= any_live;
      end

      a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
         any_live |=> irq);
      a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
         !any_live |=> !irq);
   end else begin : g_comb
      assign irq = any_live;
   end
endmodule

// File: rtl/irq_status_mask_ctrl.sv
module irq_status_mask_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 20,
   parameter int unsigned DMA_BIT  = 3,
   parameter int unsigned ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
   parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074,
   parameter bit          REG_OUT  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_pulse,
   input  logic               dma_irq,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic               bus_half,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BUS_W-1:0]   bus_wdata,
   output logic [BUS_W-1:0]   bus_rdata,
   output logic               cpu_irq
);
   if (NUM_SRC < 1 || NUM_SRC > BUS_W) begin : g_bad_n
      $error("NUM_SRC must lie in 1..32");
   end
   if (DMA_BIT >= NUM_SRC) begin : g_bad_dma
      $error("DMA_BIT must address an implemented bit");
   end

   irqc_wr_t           wdec;
   logic               rd_stat, rd_mask;
   logic [NUM_SRC-1:0] status, mask, set_vec;

   assign set_vec = src_pulse | (NUM_SRC'(dma_irq) << DMA_BIT);

   irqc_decode #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)) u_dec (
      .sel(bus_sel), .wr(bus_wr), .half(bus_half), .addr(bus_addr),
      .wdec(wdec), .rd_stat(rd_stat), .rd_mask(rd_mask));

   irqc_regs #(.NUM_SRC(NUM_SRC), .DMA_BIT(DMA_BIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wdec(wdec),
      .wd(bus_wdata[NUM_SRC-1:0]), .status(status), .mask(mask));

   irqc_line #(.NUM_SRC(NUM_SRC), .REG_OUT(REG_OUT)) u_line (
      .clk(clk), .rst_n(rst_n), .status(status), .mask(mask), .irq(cpu_irq));

   always_comb begin
      bus_rdata = '0;
      if (rd_stat)      bus_rdata[NUM_SRC-1:0] = status;
      else if (rd_mask) bus_rdata[NUM_SRC-1:0] = mask;
      if (bus_half)     bus_rdata[BUS_W-1:LANE_W] = '0;
   end

   a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stat || rd_mask) |-> bus_rdata == '0);
endmodule

// File: tb/irq_status_mask_ctrl_test.sv
module irq_status_mask_ctrl_test;
   localparam int NS = 20;
   localparam logic [11:0] A_ST = 12'h070;
   localparam logic [11:0] A_MK = 12'h074;
   localparam logic [31:0] IMPL = (32'h1 << NS) - 1;

   logic clk = 0, rst_n = 0;
   logic [NS-1:0] src_pulse = '0;
   logic dma_irq = 0, bus_sel = 0, bus_wr = 0, bus_half = 0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic cpu_irq;

   always #4 clk = ~clk;

   irq_status_mask_ctrl uut (.clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .dma_irq(dma_irq),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_half(bus_half), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq));

   int n_cmp = 0, n_bad = 0;
   logic [31:0] m_st = 0, m_mk = 0;
   logic m_irq = 0;
   bit done = 0;

   function automatic logic [31:0] nxt_st(logic [31:0] st, logic [31:0] mk, logic [31:0] pl,
                                          logic wst, logic hf, logic [31:0] wd);
      logic [31:0] keep = '1;
      if (wst) begin
         if (hf) keep[15:0] = mk[15:0] & wd[15:0];
         else    keep = mk & wd;
      end
      return ((st & keep) | pl) & IMPL;
   endfunction

   function automatic logic [31:0] nxt_mk(logic [31:0] mk, logic wmk, logic hf, logic [31:0] wd);
      if (!wmk) return mk;
      if (hf)   return {mk[31:16], wd[15:0]} & IMPL;
      return wd & IMPL;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic op(logic [NS-1:0] pl, logic d, logic sel, logic wr, logic hf,
                     logic [11:0] a, logic [31:0] wd);
      logic [31:0] pv;
      src_pulse = pl; dma_irq = d; bus_sel = sel; bus_wr = wr;
      bus_half = hf; bus_addr = a; bus_wdata = wd;
      @(posedge clk);
      pv = 32'(pl) | (32'(d) << 3);
      m_irq = |(m_st & m_mk);
      m_st = nxt_st(m_st, m_mk, pv, sel && wr && a == A_ST, hf, wd);
      m_mk = nxt_mk(m_mk, sel && wr && a == A_MK, hf, wd);
      @(negedge clk);
      src_pulse = '0; dma_irq = 0; bus_sel = 0; bus_wr = 0; bus_half = 0;
   endtask

   task automatic rd(logic [11:0] a, logic hf, output logic [31:0] v);
      bus_sel = 1; bus_wr = 0; bus_half = hf; bus_addr = a;
      #1 v = bus_rdata;
      bus_sel = 0; bus_half = 0;
   endtask

   task automatic chk_all(string req);
      logic [31:0] v;
      rd(A_ST, 0, v); chk({req, " status"}, v, m_st);
      rd(A_MK, 0, v); chk({req, " mask"}, v, m_mk);
      chk({req, " irq"}, 32'(cpu_irq), 32'(m_irq));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_all("R1 reset");
      rst_n = 1;

      // R11: pulse while masked
      op(NS'(32'h20), 0, 0, 0, 0, '0, '0);
      op('0, 0, 0, 0, 0, '0, '0);
      chk_all("R11 masked pulse latched");
      chk("R11 irq low", 32'(cpu_irq), 32'h0);
      chk("R2 pending held", m_st, 32'h20);

      // R4 + R10 upper bits
      op('0, 0, 1, 1, 0, A_MK, 32'hFFFF_FFFF);
      rd(A_MK, 0, v); chk("R4/R10 mask unused bits zero", v, IMPL);
      op('0, 0, 0, 0, 0, '0, '0);
      chk("R9 irq rises", 32'(cpu_irq), 32'h1);

      // R3
      op('0, 1, 0, 0, 0, '0, '0);
      rd(A_ST, 0, v); chk("R3 dma sets bit3", v, 32'h28);

      // R6
      op('0, 0, 1, 1, 0, A_MK, 32'h8);
      op('0, 0, 1, 1, 0, A_ST, 32'hFFFF_FFFF);
      rd(A_ST, 0, v); chk("R6 masked bit dropped", v, 32'h8);

      // R7
      op('0, 1, 1, 1, 0, A_ST, 32'h0);
      rd(A_ST, 0, v); chk("R7 pulse beats ack", v, 32'h8);
      op('0, 0, 1, 1, 0, A_ST, 32'h0);
      rd(A_ST, 0, v); chk("R5 full ack", v, 32'h0);
      op('0, 0, 0, 0, 0, '0, '0);
      chk("R9 irq falls", 32'(cpu_irq), 32'h0);

      // R8
      op('0, 0, 1, 1, 0, A_MK, 32'hFFFF_FFFF);
      op('0, 0, 1, 1, 1, A_MK, 32'hABCD_1234);
      rd(A_MK, 0, v); chk("R8 half mask write", v, 32'hF1234);
      op(NS'(32'hF0011), 0, 0, 0, 0, '0, '0);
      op('0, 0, 1, 1, 1, A_ST, 32'h0000_0000);
      rd(A_ST, 0, v); chk("R8 half status ack keeps upper", v, 32'hF0000);

      // R10
      rd(A_ST, 1, v); chk("R10 half read zero-extends", v, 32'h0);
      rd(12'h078, 0, v); chk("R10 unmapped read", v, 32'h0);
      op('0, 0, 1, 1, 0, 12'h078, 32'hFFFF_FFFF);
      chk_all("R10 unmapped write ignored");
      rd(A_ST, 0, v); rd(A_ST, 0, v); chk("R10 read no side effect", v, m_st);

      // random phase
      for (int i = 0; i < 400; i++) begin
         int k = $urandom % 8;
         logic [NS-1:0] pl = ($urandom % 4 == 0) ? NS'($urandom) : '0;
         logic [11:0] a = (k < 4) ? A_ST : (k < 7) ? A_MK : 12'h07C;
         op(pl, ($urandom % 6) == 0, k != 0, 1, ($urandom % 4) == 0, a, $urandom);
         chk_all("R5/R7 random");
      end

      // R1 mid-run reset
      rst_n = 0;
      @(posedge clk); m_st = 0; m_mk = 0; m_irq = 0;
      @(negedge clk);
      chk_all("R1 mid-run reset");
      finish_run();
   end
endmodule